// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block gathers 32 interrupt request lines into two processor-facing request wires. Software sets up each line through a small 32-bit register bus. A line can respond to a level or to an edge, and its active sense can be high or low. A per-line enable gates the line into a pending-and-enabled status word, and a per-line route bit sends it to either the normal request wire or the fast request wire.

Every line first passes through a multi-flop synchroniser. An edge-sensed line records its selected transition in a sticky pending bit. Software clears that bit by writing a one to the same bit position of the pending register. A level-sensed line has no memory: its pending bit always shows whether the synchronised line is at its active level. Reading the enabled-status register gives, in one access, every source that is both pending and enabled.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After a synchronous reset, the enable, sense-polarity, mode and route registers read 0, the enabled-status register reads 0, and both request outputs are low.
- R2: Register byte offsets: enable 0x00, pending 0x04, enabled-status 0x08, polarity 0x0C, mode 0x10, route 0x14. Bit n of each register belongs to source n. Read data is combinational from the address, and any other address reads 0.
- R3: A line whose mode bit is 0 is level-sensed. Its pending bit equals the synchronised input XNOR its polarity bit (polarity 1 = active high, 0 = active low), and writing ones to the pending register does not change it. After reset, every line is level-sensed and active low.
- R4: A line whose mode bit is 1 is edge-sensed. Polarity 1 sets its pending bit on a rising transition and polarity 0 on a falling one. The bit stays set after the input returns.
- R5: A write to offset 0x04 clears the pending bit of each edge-sensed line whose write-data bit is 1. Bits written as 0 keep their value.
- R6: If a selected edge is detected in the same cycle as an acknowledge write to that line, the pending bit stays set.
- R7: The enabled-status register reads pending AND enable, where an enable bit of 1 admits the source.
- R8: The normal request output is the registered OR of enabled-status bits whose route bit is 0. The fast request output is the registered OR of those whose route bit is 1. Each output changes one clock after the enabled-status word.
- R9: Writes to offset 0x08 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_in | input | 32 | Asynchronous interrupt request lines |
| req_norm | output | 1 | Normal interrupt request |
| req_fast | output | 1 | Fast interrupt request |

## Verification
The level path is driven with a table of line patterns: all low, all high, split halves, alternating nibbles, and single high or low bits. Each pattern is paired with its own enable, polarity and route words, so that an inverted polarity, a dropped enable bit or a swapped route shows up as a distinct wrong pending, status or output value. Edge mode is tested separately with a one-cycle rising pulse, a falling step, and an input that does not change. These show sticky capture apart from level tracking. Partial acknowledges and an acknowledge that lands in the detection cycle separate write-one-to-clear and the priority of a new edge from a plain clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned NSRC = 32;
    localparam int unsigned DW   = 32;
    localparam int unsigned AW   = 8;

    localparam logic [AW-1:0] OFF_ENABLE = 8'h00;
    localparam logic [AW-1:0] OFF_PEND   = 8'h04;
    localparam logic [AW-1:0] OFF_ACTIVE = 8'h08;
    localparam logic [AW-1:0] OFF_POLAR  = 8'h0C;
    localparam logic [AW-1:0] OFF_MODE   = 8'h10;
    localparam logic [AW-1:0] OFF_ROUTE  = 8'h14;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_PEND,
        SEL_ACTIVE,
        SEL_POLAR,
        SEL_MODE,
        SEL_ROUTE
    } reg_sel_e;

    typedef struct packed {
        src_vec_t enable;
        src_vec_t polar;
        src_vec_t mode;
        src_vec_t route;
    } line_cfg_t;

    function automatic reg_sel_e decode_addr(logic [AW-1:0] a);
        case (a)
            OFF_ENABLE: return SEL_ENABLE;
            OFF_PEND:   return SEL_PEND;
            OFF_ACTIVE: return SEL_ACTIVE;
            OFF_POLAR:  return SEL_POLAR;
            OFF_MODE:   return SEL_MODE;
            OFF_ROUTE:  return SEL_ROUTE;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic src_vec_t level_active(src_vec_t lvl, src_vec_t polar);
        return ~(lvl ^ polar);
    endfunction

    function automatic src_vec_t edge_hit(src_vec_t cur, src_vec_t prev, src_vec_t polar);
        return (polar & cur & ~prev) | (~polar & ~cur & prev);
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync
    import irqc_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t req_async,
    output src_vec_t req_sync,
    output src_vec_t req_prev
);

    localparam int unsigned LAST = STAGES - 1;

    src_vec_t chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= req_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) req_prev <= '0;
        else     req_prev <= chain[LAST];
    end

    assign req_sync = chain[LAST];

endmodule

// File: rtl/irqc_latch.sv
module irqc_latch
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t req_sync,
    input  src_vec_t req_prev,
    input  src_vec_t polar,
    input  src_vec_t mode,
    input  src_vec_t ack,
    output src_vec_t pend_q
);

    src_vec_t evt;
    src_vec_t lvl;
    src_vec_t pend_d;

    always_comb begin
        evt    = edge_hit(req_sync, req_prev, polar);
        lvl    = level_active(req_sync, polar);
        pend_d = (mode & ((pend_q & ~ack) | evt)) | (~mode & lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(pend_q & mode & ~ack) & mode & ~pend_q) == '0));

    // R6
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(evt & mode) & ~pend_q) == '0));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  src_vec_t      pend_q,
    input  src_vec_t      active,
    output line_cfg_t     cfg,
    output src_vec_t      ack,
    output logic [DW-1:0] bus_rdata
);

    reg_sel_e sel;

    assign sel = decode_addr(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (bus_we) begin
            unique case (sel)
                SEL_ENABLE: cfg.enable <= bus_wdata[NSRC-1:0];
                SEL_POLAR:  cfg.polar  <= bus_wdata[NSRC-1:0];
                SEL_MODE:   cfg.mode   <= bus_wdata[NSRC-1:0];
                SEL_ROUTE:  cfg.route  <= bus_wdata[NSRC-1:0];
                default: ;
            endcase
        end
    end

    assign ack = (bus_we && sel == SEL_PEND) ? bus_wdata[NSRC-1:0] : '0;

    always_comb begin
        unique case (sel)
            SEL_ENABLE: bus_rdata = DW'(cfg.enable);
            SEL_PEND:   bus_rdata = DW'(pend_q);
            SEL_ACTIVE: bus_rdata = DW'(active);
            SEL_POLAR:  bus_rdata = DW'(cfg.polar);
            SEL_MODE:   bus_rdata = DW'(cfg.mode);
            SEL_ROUTE:  bus_rdata = DW'(cfg.route);
            default:    bus_rdata = '0;
        endcase
    end

    // R1
    cfg_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == '0));

    // R9
    active_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_we && sel == SEL_ACTIVE) |-> $stable(cfg));

endmodule

// File: rtl/irqc_out.sv
module irqc_out
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t active,
    input  src_vec_t route,
    output logic     req_norm_q,
    output logic     req_fast_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_norm_q <= 1'b0;
            req_fast_q <= 1'b0;
        end else begin
            req_norm_q <= |(active & ~route);
            req_fast_q <= |(active & route);
        end
    end

    // R8
    norm_source_chk: assert property (@(posedge clk) disable iff (rst)
        req_norm_q |-> |($past(active & ~route)));

    // R8
    fast_source_chk: assert property (@(posedge clk) disable iff (rst)
        req_fast_q |-> |($past(active & route)));

    // R8
    quiet_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |=> (!req_norm_q && !req_fast_q));

endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] irq_in,
    output logic            req_norm,
    output logic            req_fast
);

    line_cfg_t cfg;
    src_vec_t  ack;
    src_vec_t  req_sync;
    src_vec_t  req_prev;
    src_vec_t  pend_q;
    src_vec_t  active;

    assign active = pend_q & cfg.enable;

    irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (irq_in),
        .req_sync  (req_sync),
        .req_prev  (req_prev)
    );

    irqc_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .req_sync (req_sync),
        .req_prev (req_prev),
        .polar    (cfg.polar),
        .mode     (cfg.mode),
        .ack      (ack),
        .pend_q   (pend_q)
    );

    irqc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pend_q    (pend_q),
        .active    (active),
        .cfg       (cfg),
        .ack       (ack),
        .bus_rdata (bus_rdata)
    );

    irqc_out u_out (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .route      (cfg.route),
        .req_norm_q (req_norm),
        .req_fast_q (req_fast)
    );

endmodule

// File: tb/irq_steer_ctrl_tb.sv
`timescale 1ns/1ps
module irq_steer_ctrl_tb;

    localparam logic [7:0] A_EN   = 8'h00;
    localparam logic [7:0] A_PEND = 8'h04;
    localparam logic [7:0] A_ACT  = 8'h08;
    localparam logic [7:0] A_POL  = 8'h0C;
    localparam logic [7:0] A_MODE = 8'h10;
    localparam logic [7:0] A_RT   = 8'h14;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [31:0] lines;
        logic [31:0] en;
        logic [31:0] pol;
        logic [31:0] rt;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
        '{32'h0000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000},
        '{32'h0000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF},
        '{32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'hFFFF_0000, 32'h0000_0001},
        '{32'h8000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000},
        '{32'h1234_5678, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
        '{32'h0000_0000, 32'h0001_0000, 32'h0000_0000, 32'h0001_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        req_norm;
    logic        req_fast;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_steer_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .req_norm  (req_norm),
        .req_fast  (req_fast)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_pend;
        logic [31:0] exp_act;

        settle(4);
        rst = 1'b0;
        settle(1);

        // R1 reset state
        rd(A_EN, d);   chk("R1 enable", d, 32'h0);
        rd(A_POL, d);  chk("R1 polarity", d, 32'h0);
        rd(A_MODE, d); chk("R1 mode", d, 32'h0);
        rd(A_RT, d);   chk("R1 route", d, 32'h0);
        rd(A_ACT, d);  chk("R1 status", d, 32'h0);
        chk("R1 outputs", {30'b0, req_norm, req_fast}, 32'h0);

        // table walk: level sensing, enable, routing (R3 R7 R8)
        for (int i = 0; i < NVEC; i++) begin
            wr(A_EN,  TBL[i].en);
            wr(A_POL, TBL[i].pol);
            wr(A_RT,  TBL[i].rt);
            @(negedge clk);
            irq_in = TBL[i].lines;
            settle(5);
            exp_pend = ~(TBL[i].lines ^ TBL[i].pol);
            exp_act  = exp_pend & TBL[i].en;
            rd(A_PEND, d); chk("R3 level pending", d, exp_pend);
            rd(A_ACT, d);  chk("R7 status", d, exp_act);
            chk("R8 outputs", {30'b0, req_norm, req_fast},
                {30'b0, |(exp_act & ~TBL[i].rt), |(exp_act & TBL[i].rt)});
        end

        // R9 write to status offset ignored
        wr(A_EN, 32'hFFFF_0000);
        wr(A_POL, 32'h0);
        wr(A_RT, 32'h0);
        @(negedge clk);
        irq_in = 32'h0;
        settle(5);
        rd(A_ACT, d);  chk("R7 status", d, 32'hFFFF_0000);
        wr(A_ACT, 32'h0000_0000);
        rd(A_ACT, d);  chk("R9 status after write", d, 32'hFFFF_0000);
        rd(A_EN, d);   chk("R9 enable untouched", d, 32'hFFFF_0000);

        // R3 level bits cannot be acknowledged
        wr(A_PEND, 32'hFFFF_FFFF);
        settle(2);
        rd(A_PEND, d); chk("R3 level not clearable", d, 32'hFFFF_FFFF);

        // R2 unmapped reads
        rd(8'h18, d); chk("R2 unmapped 0x18", d, 32'h0);
        rd(8'h7C, d); chk("R2 unmapped 0x7C", d, 32'h0);

        // R8 output is one cycle behind status
        wr(A_EN, 32'h0);
        settle(3);
        wr(A_EN, 32'h0000_0001);
        chk("R8 output lag", {31'b0, req_norm}, 32'h0);
        @(negedge clk);
        chk("R8 output set", {31'b0, req_norm}, 32'h1);

        // edge mode: bits 0,2 rising; bits 1,3 falling
        wr(A_EN, 32'h0);
        @(negedge clk);
        irq_in = 32'h0000_000A;
        settle(5);
        wr(A_POL, 32'h0000_0005);
        wr(A_MODE, 32'h0000_000F);
        rd(A_MODE, d); chk("R2 mode readback", d, 32'h0000_000F);
        wr(A_PEND, 32'h0000_000F);
        settle(1);
        rd(A_PEND, d); chk("R5 ack clears", d & 32'hF, 32'h0);

        // R4 rising pulse on bit 0
        @(negedge clk); irq_in = 32'h0000_000B;
        @(negedge clk); irq_in = 32'h0000_000A;
        settle(4);
        rd(A_PEND, d); chk("R4 rising sticky", d & 32'hF, 32'h1);

        // R4 falling on bit 3
        @(negedge clk); irq_in = 32'h0000_0002;
        settle(4);
        rd(A_PEND, d); chk("R4 falling", d & 32'hF, 32'h9);

        // R5 partial acknowledge
        wr(A_PEND, 32'h0000_0001);
        rd(A_PEND, d); chk("R5 partial ack", d & 32'hF, 32'h8);

        // R6 edge in the acknowledge cycle wins
        @(negedge clk); irq_in = 32'h0000_0006;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_PEND; bus_wdata = 32'h0000_0004; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_PEND, d); chk("R6 edge beats ack", d & 32'hF, 32'hC);
        wr(A_PEND, 32'h0000_0004);
        rd(A_PEND, d); chk("R5 later ack clears", d & 32'hF, 32'h8);

        // R8 fast routing of an edge source, then drop after ack
        wr(A_RT, 32'h0000_0008);
        wr(A_EN, 32'h0000_0008);
        settle(2);
        chk("R8 fast route", {30'b0, req_norm, req_fast}, 32'h1);
        wr(A_PEND, 32'h0000_0008);
        settle(2);
        chk("R5 R8 fast drops", {30'b0, req_norm, req_fast}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule